// File: doc/BRIEF.md
# Quadrature Calibration Tone Generator

This block produces a pair of digital reference signals, a cosine and a sine, at one fixed calibration frequency. The references are used downstream to pull a known injected calibration tone out of the sample streams of the sub-converters of a time-interleaved ADC. The generator runs at the sub-converter sample rate. Each enabled clock cycle advances it by one sample.

One full period of the cosine is `4*QTR` samples long. A small table, computed at elaboration time, holds that period. A modulo counter walks the table. The sine is not stored separately. It is the registered cosine stream passed through a delay line of `QTR` stages, which is exactly a quarter period, so cos(θ − π/2) = sin θ. Dropping the enable freezes the counter, the table register and the delay line together, so the quadrature relation survives any pattern of stalls.

Top module: `qcal_tone_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge leaves `cos_out` = 0, `sin_out` = 0 and `ref_valid` = 0.
- R2: Let m ≥ 1 be the number of rising edges since reset with `en` high. After the m-th such edge, `cos_out` equals C[(m−1) mod 4·QTR]. Here C[i] = round(A·cos(2π·i/(4·QTR))) and A = 2^(W−1)−1, which is 32767 for W = 16. Before the first such edge, `cos_out` is 0.
- R3: The table position wraps from 4·QTR−1 back to 0, so the cosine sequence repeats with a period of exactly 4·QTR enabled cycles.
- R4: When m ≥ QTR+1, `sin_out` equals C[(m−1−QTR) mod 4·QTR]. This is the cosine delayed by QTR enabled samples, one quarter period.
- R5: `ref_valid` is 0 while m ≤ QTR and 1 once m ≥ QTR+1. After it rises, it stays high until the next reset.
- R6: An edge with `en` low changes neither output nor `ref_valid`. When `en` returns high, the sequences continue from where they stopped.
- R7: Neither output ever shows the most negative code −2^(W−1). The largest magnitude either output reaches is A.
- R8: While `ref_valid` is 0, `sin_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sub-converter sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance one sample on this edge |
| cos_out | output | W | Signed cosine reference sample |
| sin_out | output | W | Signed sine reference sample |
| ref_valid | output | 1 | Both references meaningful (delay line filled) |

## Verification
The cosine takes one register stage: the sample for table index m−1 appears right after the m-th enabled edge. The sine takes that stage plus QTR delay stages, so it first carries data, and `ref_valid` first rises, after enabled edge QTR+1. The bench counts enabled edges itself and derives every expected value from that count, so cycles with `en` low simply do not advance the model. Outputs are sampled on the falling edge after each rising edge. That way each check sees the state left by exactly the edges the model has counted.

// File: rtl/qcal_pkg.sv
package qcal_pkg;

   localparam real QCAL_PI = 3.14159265358979323846;

   // Rounded, scaled cosine code for table index idx of a depth-entry period.
   function automatic int qcal_cos_code(input int idx, input int depth, input int amp);
      real ang;
      ang = 2.0 * QCAL_PI * real'(idx) / real'(depth);
      return int'(real'(amp) * $cos(ang));
   endfunction

endpackage

// File: rtl/qcal_phase_acc.sv
module qcal_phase_acc #(
   parameter int DEPTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("qcal_phase_acc: DEPTH must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr <= '0;
      else if (en)
         addr <= (addr == LAST) ? '0 : addr + AW'(1);
   end

   // R3
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && addr == LAST) |=> (addr == '0));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(addr));

endmodule

// File: rtl/qcal_cos_rom.sv
module qcal_cos_rom
   import qcal_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int W     = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int AMP  = (2 ** (W - 1)) - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [AW-1:0]       addr,
   output logic signed [W-1:0] data
);
   logic signed [W-1:0] table_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         localparam int CODE = qcal_cos_code(i, DEPTH, AMP);
         assign table_q[i] = W'(CODE);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         data <= '0;
      else if (en)
         data <= table_q[addr];
   end

   // R7
   rom_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (data != {1'b1, {(W-1){1'b0}}}));

endmodule

// File: rtl/qcal_tap_delay.sv
module qcal_tap_delay #(
   parameter int TAPS = 8,
   parameter int W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout
);
   logic signed [W-1:0] stage_q [TAPS];

   generate
      if (TAPS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage_q[0] <= '0;
            else if (en)
               stage_q[0] <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage_q[0] <= '0;
            else if (en)
               stage_q[0] <= din;
         end
         for (genvar s = 1; s < TAPS; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)
                  stage_q[s] <= '0;
               else if (en)
                  stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[TAPS-1];

   // R6
   delay_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(dout));

endmodule

// File: rtl/qcal_tone_gen.sv
module qcal_tone_gen #(
   parameter int QTR = 8,
   parameter int W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   output logic signed [W-1:0] cos_out,
   output logic signed [W-1:0] sin_out,
   output logic                ref_valid
);
   localparam int DEPTH = 4 * QTR;
   localparam int AW    = $clog2(DEPTH);
   localparam int FILL  = QTR + 1;
   localparam int CW    = $clog2(FILL + 1);

   generate
      if (QTR < 1 || QTR > 63) begin : g_bad_qtr
         $error("qcal_tone_gen: QTR must lie in 1..63");
      end
      if (W < 4 || W > 32) begin : g_bad_width
         $error("qcal_tone_gen: W must lie in 4..32");
      end
   endgenerate

   logic [AW-1:0] addr;
   logic [CW-1:0] fill_q;

   qcal_phase_acc #(.DEPTH(DEPTH)) i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .addr  (addr)
   );

   qcal_cos_rom #(.DEPTH(DEPTH), .W(W)) i_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .addr  (addr),
      .data  (cos_out)
   );

   qcal_tap_delay #(.TAPS(QTR), .W(W)) i_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .din   (cos_out),
      .dout  (sin_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         fill_q <= '0;
      else if (en && fill_q != CW'(FILL))
         fill_q <= fill_q + CW'(1);
   end

   assign ref_valid = (fill_q == CW'(FILL));

   // R5
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |=> ref_valid);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cos_out != {1'b1, {(W-1){1'b0}}}) && (sin_out != {1'b1, {(W-1){1'b0}}}));

   // R8
   sin_zero_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_valid |-> (sin_out == '0));

   // R6
   outputs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(cos_out) && $stable(sin_out) && $stable(ref_valid)));

endmodule

// File: tb/test_qcal_tone_gen.sv
module test_qcal_tone_gen;
   localparam int K     = 8;
   localparam int W     = 16;
   localparam int DEPTH = 4 * K;
   localparam int AMP   = 32767;
   localparam real PI   = 3.14159265358979323846;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic signed [W-1:0] cos_out, sin_out;
   logic ref_valid;

   int checks = 0;
   int errors = 0;
   int n = 0;   // enabled edges since reset
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   qcal_tone_gen #(.QTR(K), .W(W)) i_qcal_tone_gen (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cos_out(cos_out), .sin_out(sin_out), .ref_valid(ref_valid)
   );

   function automatic int exp_cos(input int idx);
      real ang;
      int  j;
      j   = idx % DEPTH;
      ang = 2.0 * PI * real'(j) / real'(DEPTH);
      return int'(real'(AMP) * $cos(ang));
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (n=%0d)", req, act, exp, n);
      end
   endtask

   task automatic check_all();
      int ec, es, ev;
      ec = (n >= 1) ? exp_cos(n - 1) : 0;
      es = (n >= K + 1) ? exp_cos(n - 1 - K) : 0;
      ev = (n >= K + 1) ? 1 : 0;
      if (n > DEPTH && ((n - 1) % DEPTH) == 0)
         check("R3 wrap", int'(cos_out), ec);
      else
         check("R2 cos", int'(cos_out), ec);
      if (n >= K + 1) check("R4 sin", int'(sin_out), es);
      else            check("R8 sin zero", int'(sin_out), 0);
      check("R5 valid", int'(ref_valid), ev);
      check("R7 range", int'(cos_out != -16'sd32768 && sin_out != -16'sd32768), 1);
   endtask

   task automatic step(input bit e);
      en = e;
      @(negedge clk);
      if (e) n++;
      check_all();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      n = 0;
      check("R1 cos", int'(cos_out), 0);
      check("R1 sin", int'(sin_out), 0);
      check("R1 valid", int'(ref_valid), 0);
      rst_n = 1'b1;
      en = 1'b0;
   endtask

   initial begin
      logic signed [W-1:0] hc, hs;
      logic hv;
      void'($urandom(32'd4242));
      do_reset();
      // R5 exact rise point and R2/R3 through two full wraps
      for (int i = 0; i < 3 * DEPTH; i++) step(1'b1);
      // R6 explicit freeze
      hc = cos_out; hs = sin_out; hv = ref_valid;
      for (int i = 0; i < 6; i++) begin
         en = 1'b0;
         @(negedge clk);
         check("R6 cos hold", int'(cos_out), int'(hc));
         check("R6 sin hold", int'(sin_out), int'(hs));
         check("R6 valid hold", int'(ref_valid), int'(hv));
      end
      step(1'b1);
      // stalls during fill
      do_reset();
      for (int i = 0; i < 3 * K; i++) step(i % 3 != 1);
      // random enable
      for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0);
      // reset mid-stream, then R1 and restart
      do_reset();
      for (int i = 0; i < 2 * DEPTH; i++) step(($urandom % 8) != 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule